// File: doc/BRIEF.md
# Multiword 16-bit ALU with programmable status flag

This block is the arithmetic and logic stage of a datapath. A 5-bit opcode is captured on the rising clock edge and runs during the cycle that edge starts. The two operands, the external carry input and the low bits of the downstream register pair are sampled combinationally during that cycle. The result, the carry output and the status flag are combinational, so the next register stage captures them at the following edge. The opcode space has four groups of eight. Sixteen are arithmetic, including a clear and four halving operations. Eight are logical. Eight are control operations: four choose the flag condition and four produce mask constants.

Words wider than 16 bits take several cycles, least significant word first. The carry output of every cycle goes into a one-bit register. The carry-from-previous form of each arithmetic operation reads that register. The carry-in form reads the external pin instead, so several units can be chained side by side. The forced-one form starts a subtraction or negation on the lowest word. The halving operations shift a word right by one bit. They take the vacated top bit from a selectable source, which lets a wide right shift run word by word from the top.

The flag condition is kept in a small state machine with four states:

| State | Flag asserts when |
|---|---|
| `FM_OVF` | signed overflow of the arithmetic result |
| `FM_HALF` | the result is within a factor of two of overflow |
| `FM_QUART` | the result is within a factor of four of overflow |
| `FM_ZERO` | the result is zero |

Transitions:
- Opcodes 18h, 19h, 1Ah and 1Bh move the machine to `FM_OVF`, `FM_HALF`, `FM_QUART` and `FM_ZERO` respectively.
- The clear opcode 00h, or reset, moves it to `FM_OVF`.
- Every other opcode holds the current state.

Top module: `alu16_core`

## Requirements
- R1: The operation performed during a cycle is the opcode on `op_in` at the rising edge that starts that cycle. Changes on `op_in` after that edge have no effect on the outputs until the next edge.
- R2: Arithmetic opcodes, with carry source listed as one/ext/prev (forced 1, `cin`, or the registered carry):
    - 01h/02h/03h give ~A + carry, using one/ext/prev.
    - 08h gives A + B + `cin`; 09h gives A + B + registered carry.
    - 0Ah/0Bh/0Ch give A + ~B + carry, using one/ext/prev.
    - 0Dh/0Eh/0Fh give ~A + B + carry, using one/ext/prev.
    - `cout` is the carry out of bit 15.
- R3: At every rising edge the `cout` value of the ending cycle is stored. The carry-from-previous forms then chain multiword additions and subtractions correctly, lowest word first.
- R4: Opcodes 04h–07h output A shifted right by one bit. The new bit 15 comes from, in order: A[15] (04h), `left_lsb` (05h), `right_lsb` (06h), B[0] (07h).
- R5: Logical opcodes: 10h A&B, 11h A&~B, 12h ~A&B, 13h A|B, 14h ~A|B, 15h A^B, 16h A, 17h ~A.
- R6: Opcodes 1Ch, 1Dh, 1Eh and 1Fh output 0001h, 00FFh, 000Fh and 5555h.
- R7: Opcodes 18h–1Bh output zero and select the flag condition overflow, half-headroom, quarter-headroom and zero respectively. The selected condition already governs `flag` in the cycle of the selecting opcode.
- R8: In overflow mode, `flag` is the XOR of the carry into bit 15 and the carry out of bit 15 for arithmetic opcodes, and is 0 for all other opcodes.
- R9: In half-headroom mode, `flag` is result[15] XOR result[14]. In quarter-headroom mode, `flag` is high unless result[15:13] is 000 or 111.
- R10: In zero mode, `flag` is high exactly when the 16-bit result is zero.
- R11: Opcode 00h outputs zero with `cout` low, clears the stored carry, and selects overflow mode. `flag` is therefore low during that cycle.
- R12: A high `rst` at a rising edge has the same effect as executing 00h.
- R13: `cout` is 0 for halving, logical, constant, flag-select and clear opcodes. The stored carry is therefore zero after any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, same as the clear opcode |
| op_in | input | 5 | Opcode, captured on the rising edge |
| a_in | input | 16 | Operand A for the executing cycle |
| b_in | input | 16 | Operand B for the executing cycle |
| cin | input | 1 | External carry for the carry-in forms |
| left_lsb | input | 1 | Bit 0 of the downstream left register |
| right_lsb | input | 1 | Bit 0 of the downstream right register |
| result | output | 16 | ALU result |
| cout | output | 1 | Carry out of bit 15 |
| flag | output | 1 | Status flag under the selected condition |

## Verification
The hardest situation to reach from the ports is the hidden one-bit carry register feeding a later operation. It can only be seen when an operation that sets it is followed directly by a carry-from-previous opcode. The stimulus therefore issues instructions back to back, with no idle cycle between them. It runs 32-bit additions and subtractions split into two words, and places a logical opcode between a carry-producing add and a zero-operand carry-from-previous add to show the carry was cleared. To prove that the opcode is latched, the driver overwrites `op_in` with its complement right after each capturing edge. The mode machine is steered through all four states, and then through a clear and a reset taken mid-run.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [4:0] {
        OP_CLEAR    = 5'h00,
        OP_NEG_ONE  = 5'h01,
        OP_NEG_EXT  = 5'h02,
        OP_NEG_PRV  = 5'h03,
        OP_HALF_SGN = 5'h04,
        OP_HALF_LFT = 5'h05,
        OP_HALF_RGT = 5'h06,
        OP_HALF_BOP = 5'h07,
        OP_ADD_EXT  = 5'h08,
        OP_ADD_PRV  = 5'h09,
        OP_SUB_ONE  = 5'h0A,
        OP_SUB_EXT  = 5'h0B,
        OP_SUB_PRV  = 5'h0C,
        OP_RSB_ONE  = 5'h0D,
        OP_RSB_EXT  = 5'h0E,
        OP_RSB_PRV  = 5'h0F,
        OP_AND      = 5'h10,
        OP_AND_NB   = 5'h11,
        OP_NA_AND   = 5'h12,
        OP_OR       = 5'h13,
        OP_NA_OR    = 5'h14,
        OP_XOR      = 5'h15,
        OP_PASS     = 5'h16,
        OP_INV      = 5'h17,
        OP_SEL_OVF  = 5'h18,
        OP_SEL_HALF = 5'h19,
        OP_SEL_QRT  = 5'h1A,
        OP_SEL_ZERO = 5'h1B,
        OP_K_ONE    = 5'h1C,
        OP_K_BYTE   = 5'h1D,
        OP_K_NIB    = 5'h1E,
        OP_K_ALT    = 5'h1F
    } alu_op_t;

    typedef enum logic [1:0] {
        FM_OVF   = 2'd0,
        FM_HALF  = 2'd1,
        FM_QUART = 2'd2,
        FM_ZERO  = 2'd3
    } fmode_t;

    typedef enum logic [1:0] {
        CS_ONE = 2'd0,
        CS_EXT = 2'd1,
        CS_PRV = 2'd2
    } csrc_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_t        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           ext_cin,
    input  logic           prv_cin,
    output logic           is_arith,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);

    logic [W-1:0] x_opd;
    logic [W-1:0] y_opd;
    csrc_t        csel;
    logic         c_lsb;
    logic [W-1:0] low_part;
    logic [1:0]   top_part;

    // operand conditioning and carry source selection
    always_comb begin
        x_opd    = '0;
        y_opd    = '0;
        csel     = CS_ONE;
        is_arith = 1'b1;
        unique case (op)
            OP_NEG_ONE: begin x_opd = ~a; csel = CS_ONE; end
            OP_NEG_EXT: begin x_opd = ~a; csel = CS_EXT; end
            OP_NEG_PRV: begin x_opd = ~a; csel = CS_PRV; end
            OP_ADD_EXT: begin x_opd = a;  y_opd = b;  csel = CS_EXT; end
            OP_ADD_PRV: begin x_opd = a;  y_opd = b;  csel = CS_PRV; end
            OP_SUB_ONE: begin x_opd = a;  y_opd = ~b; csel = CS_ONE; end
            OP_SUB_EXT: begin x_opd = a;  y_opd = ~b; csel = CS_EXT; end
            OP_SUB_PRV: begin x_opd = a;  y_opd = ~b; csel = CS_PRV; end
            OP_RSB_ONE: begin x_opd = ~a; y_opd = b;  csel = CS_ONE; end
            OP_RSB_EXT: begin x_opd = ~a; y_opd = b;  csel = CS_EXT; end
            OP_RSB_PRV: begin x_opd = ~a; y_opd = b;  csel = CS_PRV; end
            default:    is_arith = 1'b0;
        endcase
    end

    always_comb begin
        unique case (csel)
            CS_ONE:  c_lsb = 1'b1;
            CS_EXT:  c_lsb = ext_cin;
            CS_PRV:  c_lsb = prv_cin;
            default: c_lsb = 1'b0;
        endcase
    end

    // split at the sign bit so the carry into it is visible
    assign low_part = {1'b0, x_opd[W-2:0]} + {1'b0, y_opd[W-2:0]} + {{(W-1){1'b0}}, c_lsb};
    assign top_part = {1'b0, x_opd[W-1]} + {1'b0, y_opd[W-1]} + {1'b0, low_part[W-1]};

    assign sum  = {top_part[0], low_part[W-2:0]};
    assign cout = is_arith & top_part[1];
    assign ovf  = is_arith & (top_part[1] ^ low_part[W-1]);

endmodule

// File: rtl/alu16_misc.sv
module alu16_misc
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_t        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           left_lsb,
    input  logic           right_lsb,
    output logic [W-1:0]   res
);

    localparam logic [W-1:0] K_ONE  = W'(1);
    localparam logic [W-1:0] K_BYTE = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};
    localparam logic [W-1:0] K_NIB  = W'(4'hF);

    logic [W-1:0] k_alt;

    // alternating mask: even positions set
    for (genvar gi = 0; gi < W; gi++) begin : g_alt
        assign k_alt[gi] = 1'((gi % 2) == 0);
    end

    always_comb begin
        unique case (op)
            OP_HALF_SGN: res = {a[W-1],    a[W-1:1]};
            OP_HALF_LFT: res = {left_lsb,  a[W-1:1]};
            OP_HALF_RGT: res = {right_lsb, a[W-1:1]};
            OP_HALF_BOP: res = {b[0],      a[W-1:1]};
            OP_AND:      res = a & b;
            OP_AND_NB:   res = a & ~b;
            OP_NA_AND:   res = ~a & b;
            OP_OR:       res = a | b;
            OP_NA_OR:    res = ~a | b;
            OP_XOR:      res = a ^ b;
            OP_PASS:     res = a;
            OP_INV:      res = ~a;
            OP_K_ONE:    res = K_ONE;
            OP_K_BYTE:   res = K_BYTE;
            OP_K_NIB:    res = K_NIB;
            OP_K_ALT:    res = k_alt;
            default:     res = '0;
        endcase
    end

endmodule

// File: rtl/alu16_flag.sv
module alu16_flag
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  alu_op_t        op,
    input  logic [W-1:0]   res,
    input  logic           ovf,
    output logic           flag
);

    fmode_t state;
    fmode_t state_nx;

    // next condition: selecting and clearing opcodes move it
    always_comb begin
        state_nx = state;
        unique case (op)
            OP_CLEAR:    state_nx = FM_OVF;
            OP_SEL_OVF:  state_nx = FM_OVF;
            OP_SEL_HALF: state_nx = FM_HALF;
            OP_SEL_QRT:  state_nx = FM_QUART;
            OP_SEL_ZERO: state_nx = FM_ZERO;
            default:     state_nx = state;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FM_OVF;
        end else begin
            state <= state_nx;
        end
    end

    // output: the condition named this cycle applies at once
    always_comb begin
        unique case (state_nx)
            FM_OVF:   flag = ovf;
            FM_HALF:  flag = res[W-1] ^ res[W-2];
            FM_QUART: flag = !((res[W-1:W-3] == 3'b000) || (res[W-1:W-3] == 3'b111));
            FM_ZERO:  flag = (res == '0);
            default:  flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [4:0]     op_in,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           cin,
    input  logic           left_lsb,
    input  logic           right_lsb,
    output logic [W-1:0]   result,
    output logic           cout,
    output logic           flag
);

    alu_op_t      op_q;
    logic         carry_q;
    logic         is_arith;
    logic [W-1:0] sum;
    logic [W-1:0] misc_res;
    logic         ovf;

    // opcode latch; reset loads the clear opcode
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= OP_CLEAR;
        end else begin
            op_q <= alu_op_t'(op_in);
        end
    end

    // carry register: captures every cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= cout;
        end
    end

    alu16_arith #(.W(W)) u_arith (
        .op       (op_q),
        .a        (a_in),
        .b        (b_in),
        .ext_cin  (cin),
        .prv_cin  (carry_q),
        .is_arith (is_arith),
        .sum      (sum),
        .cout     (cout),
        .ovf      (ovf)
    );

    alu16_misc #(.W(W)) u_misc (
        .op        (op_q),
        .a         (a_in),
        .b         (b_in),
        .left_lsb  (left_lsb),
        .right_lsb (right_lsb),
        .res       (misc_res)
    );

    assign result = is_arith ? sum : misc_res;

    alu16_flag #(.W(W)) u_flag (
        .clk  (clk),
        .rst  (rst),
        .op   (op_q),
        .res  (result),
        .ovf  (ovf),
        .flag (flag)
    );

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [4:0]   op_in,
    input logic [W-1:0] result,
    input logic         cout,
    input logic         flag
);

    AST_RESET_LIKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0) && !cout && !flag);  // R12

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == 5'h00) |-> (result == '0) && !cout && !flag);  // R11

    AST_SELECT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in[4:2]) == 3'b110) |-> (result == '0));  // R7

    AST_ZERO_MODE_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == 5'h1B) |-> flag);  // R10

    AST_ONE_CONSTANT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == 5'h1C) |-> (result == W'(1)));  // R6

    AST_UPPER_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in[4])) |-> !cout);  // R13

endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_in  (op_in),
    .result (result),
    .cout   (cout),
    .flag   (flag)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_in = 5'h00;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        cin = 1'b0;
    logic        left_lsb = 1'b0;
    logic        right_lsb = 1'b0;
    logic [15:0] result;
    logic        cout;
    logic        flag;

    always #10 clk = ~clk;

    alu16_core uut (
        .clk(clk), .rst(rst), .op_in(op_in), .a_in(a_in), .b_in(b_in),
        .cin(cin), .left_lsb(left_lsb), .right_lsb(right_lsb),
        .result(result), .cout(cout), .flag(flag)
    );

    typedef struct {
        logic [15:0] r;
        logic        c;
        logic        f;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   bad = 0;
    bit   finished = 0;
    logic m_carry = 1'b0;
    int   m_mode = 0;

    function automatic string tag_of(input logic [4:0] op);
        if (op == 5'h00) return "R11";
        if (op >= 5'h04 && op <= 5'h07) return "R4";
        if (op <= 5'h0F) return "R2";
        if (op <= 5'h17) return "R5";
        if (op <= 5'h1B) return "R7";
        return "R6";
    endfunction

    // driver: latch op, present operands, predict from the requirements
    task automatic issue(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input logic l, input logic r, input string tag);
        exp_t        e;
        logic [15:0] x, y, res;
        logic [16:0] full;
        logic        c, co, v;
        int          o;
        o = int'(op);
        @(negedge clk);
        op_in = op;
        @(posedge clk);
        #1;
        a_in = a; b_in = b; cin = ci; left_lsb = l; right_lsb = r;
        op_in = ~op;  // R1: must not disturb the executing opcode
        x = '0; y = '0; c = 1'b0; co = 1'b0; v = 1'b0; res = '0;
        if (o != 0 && o <= 15 && !(o >= 4 && o <= 7)) begin
            if (o <= 3)       begin x = ~a; y = '0; end
            else if (o <= 9)  begin x = a;  y = b;  end
            else if (o <= 12) begin x = a;  y = ~b; end
            else              begin x = ~a; y = b;  end
            if (o == 8) c = ci;
            else if (o == 9) c = m_carry;
            else begin
                case ((o <= 3) ? o - 1 : (o <= 12) ? o - 10 : o - 13)
                    0: c = 1'b1;
                    1: c = ci;
                    default: c = m_carry;
                endcase
            end
            full = {1'b0, x} + {1'b0, y} + {16'b0, c};
            res  = full[15:0];
            co   = full[16];
            v    = (x[15] == y[15]) && (res[15] != x[15]);
        end else begin
            case (o)
                4:  res = {a[15], a[15:1]};
                5:  res = {l, a[15:1]};
                6:  res = {r, a[15:1]};
                7:  res = {b[0], a[15:1]};
                16: res = a & b;
                17: res = a & ~b;
                18: res = ~a & b;
                19: res = a | b;
                20: res = ~a | b;
                21: res = a ^ b;
                22: res = a;
                23: res = ~a;
                28: res = 16'h0001;
                29: res = 16'h00FF;
                30: res = 16'h000F;
                31: res = 16'h5555;
                default: res = '0;
            endcase
            if (o == 0) m_mode = 0;
            if (o >= 24 && o <= 27) m_mode = o - 24;
        end
        e.r = res;
        e.c = co;
        case (m_mode)
            0: e.f = v;
            1: e.f = res[15] ^ res[14];
            2: e.f = !(res[15:13] == 3'b000 || res[15:13] == 3'b111);
            default: e.f = (res == 16'h0000);
        endcase
        m_carry = co;
        e.tag = (tag == "") ? tag_of(op) : tag;
        sb.push_back(e);
    endtask

    // monitor: compare one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (result !== e.r || cout !== e.c || flag !== e.f) begin
                    bad++;
                    $display("FAIL %s: result=%h cout=%b flag=%b expected result=%h cout=%b flag=%b",
                             e.tag, result, cout, flag, e.r, e.c, e.f);
                end
            end
        end
    end

    task automatic check_reset_state(input string what);
        checks++;
        if (result !== 16'h0000 || cout !== 1'b0 || flag !== 1'b0) begin
            bad++;
            $display("FAIL R12 %s: result=%h cout=%b flag=%b expected result=0000 cout=0 flag=0",
                     what, result, cout, flag);
        end
    endtask

    task automatic mid_reset();
        @(negedge clk);
        rst = 1'b1;
        op_in = 5'h1B;  // must be overridden by reset
        @(negedge clk);
        @(negedge clk);
        check_reset_state("mid-run");
        rst = 1'b0;
        op_in = 5'h00;
        m_carry = 1'b0;
        m_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("power-up");
        rst = 1'b0;

        // R1: opcode latch, op_in scrambled after each capture
        issue(5'h16, 16'h1234, 16'h0000, 0, 0, 0, "R1");
        issue(5'h15, 16'h00FF, 16'h0F0F, 0, 0, 0, "R1");
        // R2: carry source variants
        issue(5'h01, 16'h0005, 16'h0000, 0, 0, 0, "R2");
        issue(5'h02, 16'h0005, 16'h0000, 0, 0, 0, "R2");
        issue(5'h0A, 16'h0009, 16'h0003, 0, 0, 0, "R2");
        issue(5'h0E, 16'h0003, 16'h0009, 1, 0, 0, "R2");
        issue(5'h08, 16'h8000, 16'h8000, 1, 0, 0, "R2");
        // R3: 32-bit add 0001FFFF + 00000001, then 32-bit subtract
        issue(5'h08, 16'hFFFF, 16'h0001, 0, 0, 0, "R3");
        issue(5'h09, 16'h0001, 16'h0000, 0, 0, 0, "R3");
        issue(5'h0A, 16'h0000, 16'h0001, 0, 0, 0, "R3");
        issue(5'h0C, 16'h0005, 16'h0000, 0, 0, 0, "R3");
        issue(5'h0D, 16'h0001, 16'h0000, 0, 0, 0, "R3");
        issue(5'h0F, 16'h0000, 16'h0004, 0, 0, 0, "R3");
        issue(5'h03, 16'h0000, 16'h0000, 0, 0, 0, "R3");
        // R13: logical op clears the stored carry
        issue(5'h08, 16'hFFFF, 16'hFFFF, 1, 0, 0, "R13");
        issue(5'h13, 16'hFFFF, 16'h0000, 0, 0, 0, "R13");
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, "R13");
        issue(5'h04, 16'hFFFF, 16'h0000, 0, 0, 0, "R13");
        // R4: halving fill sources
        issue(5'h04, 16'h8002, 16'h0000, 0, 0, 0, "R4");
        issue(5'h05, 16'h0004, 16'h0000, 0, 1, 0, "R4");
        issue(5'h06, 16'h0004, 16'h0000, 0, 0, 1, "R4");
        issue(5'h06, 16'h0004, 16'h0000, 0, 1, 0, "R4");
        issue(5'h07, 16'h0004, 16'h0001, 0, 0, 0, "R4");
        // R5 and R6
        for (int k = 16; k < 24; k++) issue(5'(k), 16'hC3A5, 16'h0FF0, 0, 0, 0, "R5");
        for (int k = 28; k < 32; k++) issue(5'(k), 16'hFFFF, 16'hFFFF, 0, 0, 0, "R6");
        // R8: signed overflow in overflow mode
        issue(5'h08, 16'h7FFF, 16'h0001, 0, 0, 0, "R8");
        issue(5'h0A, 16'h8000, 16'h0001, 0, 0, 0, "R8");
        issue(5'h08, 16'hFFFF, 16'h0001, 0, 0, 0, "R8");
        // R9: headroom modes
        issue(5'h19, 16'h1234, 16'h0000, 0, 0, 0, "R7");
        issue(5'h16, 16'h4000, 16'h0000, 0, 0, 0, "R9");
        issue(5'h16, 16'h2000, 16'h0000, 0, 0, 0, "R9");
        issue(5'h1A, 16'h0000, 16'h0000, 0, 0, 0, "R7");
        issue(5'h16, 16'h2000, 16'h0000, 0, 0, 0, "R9");
        issue(5'h16, 16'h1000, 16'h0000, 0, 0, 0, "R9");
        issue(5'h16, 16'hC000, 16'h0000, 0, 0, 0, "R9");
        issue(5'h16, 16'hE000, 16'h0000, 0, 0, 0, "R9");
        // R10: zero mode, active during its own select
        issue(5'h1B, 16'hFFFF, 16'h0000, 0, 0, 0, "R10");
        issue(5'h15, 16'h5A5A, 16'h5A5A, 0, 0, 0, "R10");
        issue(5'h15, 16'h5A5A, 16'h5A5B, 0, 0, 0, "R10");
        // R11: clear restores overflow mode and zero carry
        issue(5'h08, 16'hFFFF, 16'h0002, 0, 0, 0, "R11");
        issue(5'h00, 16'hFFFF, 16'hFFFF, 1, 1, 1, "R11");
        issue(5'h16, 16'h0000, 16'h0000, 0, 0, 0, "R11");
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, "R11");
        // R12: reset mid-run after zero mode and a stored carry
        issue(5'h1B, 16'h0000, 16'h0000, 0, 0, 0, "R12");
        issue(5'h08, 16'hFFFF, 16'h0001, 0, 0, 0, "R12");
        mid_reset();
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, "R12");
        issue(5'h16, 16'h0000, 16'h0000, 0, 0, 0, "R12");
        // mixed traffic over all opcodes
        for (int i = 0; i < 400; i++) begin
            issue(5'($urandom), 16'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), "");
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule